// File: doc/BRIEF.md
# Serial Transmitter with Queued Write Buffer

This block turns parallel characters into asynchronous serial frames on a single output line. Software-facing logic presents a character on a write strobe. The character is held either in a one-entry buffer or, when queue mode is on, in an eight-entry first-in first-out store. The serializer then sends each character as a low start bit, the data bits least significant first, and one or two high stop bits. Timing comes from an external bit-rate pulse: each pulse marks the boundary between two bit periods.

Raising the enable makes the line stay high for one whole frame length before the first character starts. Dropping the enable stops the bit engine at once. The character on the wire is thrown away and the line returns high, but characters still waiting in the store are kept. A status output reports when enough free slots exist in the queue, against a level picked by a 3-bit code. A completion flag reports that the last stop bit has ended and nothing else is waiting.

Top module: `sertx_top`

## Requirements
- R1: `word_sel` selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits, and 2'b11 is treated as 8 bits. For shorter lengths only the low bits of the written word are sent.
- R2: Each frame starts with one low bit period. The data bits follow with bit 0 first, and the stop bits are high.
- R3: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two. With back-to-back characters, consecutive start bits are therefore (1 + data bits + stop bits) bit periods apart.
- R4: After `tx_en` rises, the line stays high for 1 + data bits + stop bits periods before the first start bit can begin.
- R5: With `fifo_mode`=1, up to 8 characters are queued and sent in write order. `fifo_full` is 1 when 8 are held, and a write made while full is dropped.
- R6: With `fifo_mode`=0, the store holds one character. `fifo_full` is 1 once it is occupied, and a second write made before it is sent is dropped.
- R7: With `fifo_mode`=1, `thresh_flag` is 1 when the free slots (8 minus held entries) are at least the level for `thresh_code`: 0→1, 1→2, 2→4, 3→6, 4→7, 5 to 7→8. With `fifo_mode`=0, `thresh_flag` is 0.
- R8: Clearing `tx_en` during a frame abandons that character. The line is high from the next cycle for as long as `tx_en` stays low, and queued characters are kept. After re-enable, an idle frame is sent and then the next queued character.
- R9: Writes made while `tx_en` is low are not stored.
- R10: `tx_done` is 0 after reset. It becomes 1 in the cycle after the bit-rate pulse that ends a frame's last stop bit, provided no character is waiting. An accepted write clears it.
- R11: In reset, `tx_line` is 1, `fifo_empty` is 1, and `fifo_full`, `thresh_flag` and `tx_done` are 0.
- R12: While enabled, `tx_line` changes only in the cycle after a `baud_tick` pulse. With no pulses, a queued character is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| word_sel | input | 2 | Data length select |
| two_stop | input | 1 | 1 selects two stop bits |
| fifo_mode | input | 1 | 1 selects the 8-entry queue, 0 the single buffer |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Character to send |
| baud_tick | input | 1 | One-cycle pulse at each bit boundary |
| thresh_code | input | 3 | Free-slot level select |
| tx_line | output | 1 | Serial output, idles high |
| thresh_flag | output | 1 | Free slots have reached the selected level |
| fifo_full | output | 1 | No room for another write |
| fifo_empty | output | 1 | Nothing waiting to be sent |
| tx_done | output | 1 | Last frame finished and nothing pending |

## Verification
The serializer is driven with three data lengths and both stop counts. Data values are chosen so that a bit-order swap, a wrong length or a missing stop bit each produce a different decoded value or start-to-start spacing. Queue behaviour is tried with pulses paused, so that fill levels stay fixed. At each level from empty to full, every threshold code is compared, which separates an off-by-one level from the right one. It also shows that a ninth write is dropped. Separate patterns check that a mid-frame disable loses only the active character, that writes while disabled leave the store empty, and that the single-buffer mode keeps only the first of two writes.

// File: rtl/sertx_pkg.sv
// Shared definitions for the serial transmitter.
// Assumes the data word is at most 9 bits wide.
package sertx_pkg;

    // Serializer states
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE_FR,
        ST_READY,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    // Width of the bit counter: a frame is at most 12 bit periods
    localparam int CNT_W = 4;

    // Data bit count for a length code (2'b11 falls back to 8)
    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   word_bits = CNT_W'(7);
            2'b10:   word_bits = CNT_W'(9);
            default: word_bits = CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
// Character store for the transmitter.
// Acts as a DEPTH-entry queue, or as a single-entry buffer when single_mode
// is set. Writes made while full and pops made while empty are ignored.
// Assumes DEPTH is a power of two.
module sertx_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           single_mode,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               pop_data,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic [WIDTH-1:0] slot_q [DEPTH];
    logic             push_ok, pop_ok;

    // Qualify requests against current occupancy
    always_comb begin
        empty   = (count_q == '0);
        full    = single_mode ? !empty : (count_q == CW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // One storage register per slot, written when the write pointer selects it
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[gi] <= '0;
            else if (push_ok && (wr_ptr_q == PW'(gi)))
                slot_q[gi] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + PW'(1);
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + PW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Head of queue presented without delay
    always_comb begin
        pop_data = slot_q[rd_ptr_q];
        count    = count_q;
    end

endmodule

// File: rtl/sertx_thresh.sv
// Free-slot level detector.
// Compares free slots (DEPTH - count) against the level chosen by a 3-bit code.
// Assumes DEPTH is a multiple of 8 so that every level is a whole number.
module sertx_thresh #(
    parameter int DEPTH = 8
) (
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [2:0]                 code,
    input  logic                       enable,
    output logic                       flag
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] free_slots;
    logic [CW-1:0] level;

    // Level for each code in eighths of the depth
    always_comb begin
        case (code)
            3'd0:    level = CW'(DEPTH / 8);
            3'd1:    level = CW'(DEPTH / 4);
            3'd2:    level = CW'(DEPTH / 2);
            3'd3:    level = CW'((3 * DEPTH) / 4);
            3'd4:    level = CW'((7 * DEPTH) / 8);
            default: level = CW'(DEPTH);
        endcase
    end

    // Free-slot comparison, gated by queue mode
    always_comb begin
        free_slots = CW'(DEPTH) - count;
        flag       = enable && (free_slots >= level);
    end

endmodule

// File: rtl/sertx_shifter.sv
// Frame serializer.
// Sends an idle frame after enable, then start, data (LSB first) and stop bits.
// Each state is held until baud_tick marks the next bit boundary.
// Dropping tx_en returns to the off state and discards the active character.
// Assumes DW <= 9.
module sertx_shifter #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          baud_tick,
    input  logic [1:0]    word_sel,
    input  logic          two_stop,
    input  logic          have_data,
    input  logic [DW-1:0] load_data,
    output logic          launch,
    output logic          frame_done,
    output logic          tx_line
);
    import sertx_pkg::*;

    tx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    shreg_q;
    logic [CNT_W-1:0] nbits;
    logic [CNT_W-1:0] frame_len;
    logic             step;
    logic             stop_end;
    logic             idle_end;

    // Frame geometry and boundary detection
    always_comb begin
        nbits      = word_bits(word_sel);
        frame_len  = CNT_W'(1) + nbits + (two_stop ? CNT_W'(2) : CNT_W'(1));
        step       = tx_en && baud_tick;
        stop_end   = (state_q == ST_STOP) && (!two_stop || (cnt_q == CNT_W'(1)));
        idle_end   = (state_q == ST_IDLE_FR) && (cnt_q == frame_len - CNT_W'(1));
        launch     = step && have_data && (stop_end || idle_end || (state_q == ST_READY));
        frame_done = step && !have_data && stop_end;
    end

    // Serializer state, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!tx_en) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else if (launch) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            shreg_q <= load_data;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_q <= ST_IDLE_FR;
                    cnt_q   <= '0;
                end
                ST_IDLE_FR: begin
                    if (baud_tick) begin
                        if (idle_end) begin
                            state_q <= ST_READY;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_READY: begin
                    state_q <= ST_READY;
                end
                ST_START: begin
                    if (baud_tick) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                    end
                end
                ST_DATA: begin
                    if (baud_tick) begin
                        shreg_q <= shreg_q >> 1;
                        if (cnt_q == nbits - CNT_W'(1)) begin
                            state_q <= ST_STOP;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (baud_tick) begin
                        if (stop_end) begin
                            state_q <= ST_READY;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    // Line level from current state
    always_comb begin
        case (state_q)
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = shreg_q[0];
            default:  tx_line = 1'b1;
        endcase
    end

endmodule

// File: rtl/sertx_top.sv
// Serial transmitter top: write qualification, character store, level
// detector, serializer and completion flag.
// Assumes baud_tick is a one-cycle pulse per bit period.
module sertx_top #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [1:0]        word_sel,
    input  logic              two_stop,
    input  logic              fifo_mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic [2:0]        thresh_code,
    output logic              tx_line,
    output logic              thresh_flag,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              tx_done
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              accept;
    logic              launch;
    logic              frame_done;
    logic [DATA_W-1:0] head_data;
    logic [CW-1:0]     count;
    logic              done_q;

    // Writes are taken only while enabled and not full
    always_comb accept = wr_valid && tx_en && !fifo_full;

    sertx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_mode(!fifo_mode),
        .push       (wr_valid && tx_en),
        .push_data  (wr_data),
        .pop        (launch),
        .pop_data   (head_data),
        .count      (count),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    sertx_thresh #(.DEPTH(DEPTH)) level_i (
        .count (count),
        .code  (thresh_code),
        .enable(fifo_mode),
        .flag  (thresh_flag)
    );

    sertx_shifter #(.DW(DATA_W)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .word_sel  (word_sel),
        .two_stop  (two_stop),
        .have_data (!fifo_empty),
        .load_data (head_data),
        .launch    (launch),
        .frame_done(frame_done),
        .tx_line   (tx_line)
    );

    // Completion flag: set at end of last frame, cleared by a new write
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (accept)     done_q <= 1'b0;
        else if (frame_done) done_q <= 1'b1;
    end

    always_comb tx_done = done_q;

endmodule

// File: rtl/sertx_checker.sv
// Port-level properties of the serial transmitter, bound to sertx_top.
module sertx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       fifo_mode,
    input logic [2:0] thresh_code,
    input logic       baud_tick,
    input logic       tx_line,
    input logic       thresh_flag,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       tx_done
);
    p_line_high_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && $past(!tx_en)) |-> tx_line);

    p_no_store_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && fifo_empty) |=> fifo_empty);

    p_full_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    p_level_all_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && thresh_code == 3'd5) |-> (thresh_flag == fifo_empty));

    p_level_off_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !thresh_flag);

    p_bit_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && !$past(baud_tick)) |-> $stable(tx_line));

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (fifo_empty && tx_line));

endmodule

bind sertx_top sertx_checker chk_i (.*);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] word_sel = 2'b01;
    logic       two_stop = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic [2:0] thresh_code = 3'd0;
    logic       tx_line, thresh_flag, fifo_full, fifo_empty, tx_done;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  tick_on = 1'b0;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .word_sel(word_sel),
        .two_stop(two_stop), .fifo_mode(fifo_mode), .wr_valid(wr_valid),
        .wr_data(wr_data), .baud_tick(baud_tick), .thresh_code(thresh_code),
        .tx_line(tx_line), .thresh_flag(thresh_flag), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .tx_done(tx_done)
    );

    always #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Bit-rate pulse generator, one pulse every DIV cycles when running
    initial begin
        int div_cnt = 0;
        forever begin
            @(negedge clk);
            if (tick_on) begin
                baud_tick = (div_cnt == DIV - 1);
                div_cnt   = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_en = 1'b0; wr_valid = 1'b0; tick_on = 1'b0;
        fifo_mode = 1'b0; word_sel = 2'b01; two_stop = 1'b0; thresh_code = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_fall(input int limit, output bit found);
        found = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (tx_line == 1'b0) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    // Decode one frame; checks start and stop levels
    task automatic recv(input string tag, input int nbits, input int nstop,
                        output int d, output int t_fall);
        bit found;
        d = 0;
        wait_fall(4000, found);
        t_fall = cyc;
        chk({tag, " start seen"}, int'(found), 1);
        repeat (DIV / 2) @(negedge clk);
        chk({tag, " start low"}, int'(tx_line), 0);
        for (int b = 0; b < nbits; b++) begin
            repeat (DIV) @(negedge clk);
            d = d | (int'(tx_line) << b);
        end
        for (int s = 0; s < nstop; s++) begin
            repeat (DIV) @(negedge clk);
            chk({tag, " stop high"}, int'(tx_line), 1);
        end
    endtask

    function automatic int level_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 7;
            default: return 8;
        endcase
    endfunction

    // R11: reset values
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 tx_line", int'(tx_line), 1);
        chk("R11 fifo_empty", int'(fifo_empty), 1);
        chk("R11 fifo_full", int'(fifo_full), 0);
        chk("R11 thresh_flag", int'(thresh_flag), 0);
        chk("R11 tx_done", int'(tx_done), 0);
    endtask

    // R4, R2, R1 (8 bit), R3 (one stop), R10
    task automatic t_idle_and_8bit();
        int d, t0, t1, t2;
        do_reset();
        fifo_mode = 1'b1; word_sel = 2'b01; two_stop = 1'b0; tick_on = 1'b1;
        tx_en = 1'b1; t0 = cyc;
        @(negedge clk);
        wr(9'h0A5);
        wr(9'h13C);
        recv("R2 8bit first", 8, 1, d, t1);
        chk("R2 8bit data", d, 'hA5);
        chk("R4 idle frame wait", int'((t1 - t0) >= 9 * DIV && (t1 - t0) <= 10 * DIV + 3), 1);
        recv("R1 8bit second", 8, 1, d, t2);
        chk("R1 8bit masked", d, 'h3C);
        chk("R3 one stop spacing", t2 - t1, 10 * DIV);
        repeat (DIV) @(negedge clk);
        chk("R10 done set", int'(tx_done), 1);
        wr(9'h001);
        chk("R10 done cleared by write", int'(tx_done), 0);
    endtask

    // R1 (7 bit), R3 (two stops)
    task automatic t_7bit_two_stop();
        int d, t1, t2;
        do_reset();
        fifo_mode = 1'b1; word_sel = 2'b00; two_stop = 1'b1; tick_on = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);
        wr(9'h1D5);
        wr(9'h033);
        recv("R1 7bit first", 7, 2, d, t1);
        chk("R1 7bit data", d, 'h55);
        recv("R1 7bit second", 7, 2, d, t2);
        chk("R1 7bit data2", d, 'h33);
        chk("R3 two stop spacing", t2 - t1, 10 * DIV);
    endtask

    // R1 (9 bit), R2 bit order
    task automatic t_9bit();
        int d, t1, t2;
        do_reset();
        fifo_mode = 1'b1; word_sel = 2'b10; two_stop = 1'b0; tick_on = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);
        wr(9'h1C3);
        wr(9'h001);
        recv("R1 9bit first", 9, 1, d, t1);
        chk("R1 9bit data", d, 'h1C3);
        recv("R2 9bit lsb", 9, 1, d, t2);
        chk("R2 9bit lsb data", d, 'h001);
        chk("R1 9bit spacing", t2 - t1, 11 * DIV);
    endtask

    // R12, R5, R7: fill with pulses paused, then drain in order
    task automatic t_queue_and_levels();
        int d, t;
        bit found;
        do_reset();
        fifo_mode = 1'b1; word_sel = 2'b01; tx_en = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= 8; k++) begin
            for (int c = 0; c < 8; c++) begin
                thresh_code = 3'(c);
                #0.5;
                if (int'(thresh_flag) != int'((8 - k) >= level_of(c)))
                    chk($sformatf("R7 level k=%0d code=%0d", k, c), int'(thresh_flag),
                        int'((8 - k) >= level_of(c)));
                else
                    n_chk++;
            end
            chk($sformatf("R5 full at %0d", k), int'(fifo_full), int'(k == 8));
            if (k < 8) wr(9'(8'h10 + k));
        end
        wr(9'h0EE);
        chk("R5 still full after extra write", int'(fifo_full), 1);
        wait_fall(60, found);
        chk("R12 no start without pulses", int'(found), 0);
        tick_on = 1'b1;
        for (int k = 0; k < 8; k++) begin
            recv("R5 drain", 8, 1, d, t);
            chk($sformatf("R5 order %0d", k), d, 8'h10 + k);
        end
        wait_fall(40 * DIV, found);
        chk("R5 dropped write not sent", int'(found), 0);
        chk("R5 empty after drain", int'(fifo_empty), 1);
        chk("R10 done after drain", int'(tx_done), 1);
    endtask

    // R6: single buffer keeps only the first write
    task automatic t_single_buffer();
        int d, t;
        bit found;
        do_reset();
        fifo_mode = 1'b0; tx_en = 1'b1;
        @(negedge clk);
        wr(9'h081);
        chk("R6 full after one", int'(fifo_full), 1);
        chk("R7 flag off in single mode", int'(thresh_flag), 0);
        wr(9'h07E);
        tick_on = 1'b1;
        recv("R6 single", 8, 1, d, t);
        chk("R6 first kept", d, 'h81);
        wait_fall(30 * DIV, found);
        chk("R6 second dropped", int'(found), 0);
    endtask

    // R9: writes while disabled are not stored
    task automatic t_disabled_writes();
        bit found;
        do_reset();
        fifo_mode = 1'b1; tx_en = 1'b0;
        wr(9'h0F0);
        wr(9'h00F);
        chk("R9 empty after disabled writes", int'(fifo_empty), 1);
        tx_en = 1'b1; tick_on = 1'b1;
        wait_fall(40 * DIV, found);
        chk("R9 nothing sent", int'(found), 0);
    endtask

    // R8: mid-frame disable drops the active character only
    task automatic t_abort();
        int d, t;
        bit found;
        bit low_seen = 1'b0;
        do_reset();
        fifo_mode = 1'b1; word_sel = 2'b01; tick_on = 1'b1; tx_en = 1'b1;
        @(negedge clk);
        wr(9'h000);
        wr(9'h03C);
        wait_fall(4000, found);
        chk("R8 first frame started", int'(found), 1);
        repeat (3 * DIV) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4 * DIV; i++) begin
            @(negedge clk);
            if (tx_line == 1'b0) low_seen = 1'b1;
        end
        chk("R8 line high while disabled", int'(low_seen), 0);
        chk("R8 queued kept", int'(fifo_empty), 0);
        tx_en = 1'b1;
        recv("R8 resumed", 8, 1, d, t);
        chk("R8 next queued sent", d, 'h3C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_idle_and_8bit();
        t_7bit_two_stop();
        t_9bit();
        t_queue_and_levels();
        t_single_buffer();
        t_disabled_writes();
        t_abort();
        finish_run();
    end

endmodule